// File: doc/BRIEF.md
# Flag-Producing Integer ALU

A purely combinational arithmetic and logic unit for a small processor core. It takes two operands, a 4-bit function code, the present condition-code word and the present program counter. In the same evaluation it returns a result word and a new condition-code word. The default build is 16 bits wide, and a 32-bit build only needs a parameter change. The surrounding core supplies the current flags so that functions which do not touch a flag can pass it through unchanged. It writes the returned word back as the next flag state.

The unit covers the following functions:
- plain, carry-chained and reverse add/subtract;
- the three bitwise operations;
- a low-half multiply;
- arithmetic and logical right shifts;
- a program-counter pass-through for call linkage;
- an upper-half immediate load.

The division code and the two reserved codes give a zero result and leave the flags as they were.

Top module: `flag_alu`

## Requirements
- R1: Function 0 (add) gives A+B, and function 2 (add with carry) gives A+B+Cin, both truncated to the word width. Cin is bit 1 of `ccrIn`. C is the carry out of the top bit, and V is set on two's-complement overflow.
- R2: Function 1 (subtract) gives A-B, and function 3 (subtract with carry) gives A-B-(1-Cin). C means "no borrow": it is 1 when the unsigned true difference is not negative. V flags signed overflow.
- R3: Function 4 (reverse subtract) gives B-A. Its flags equal those of subtract with the operands swapped.
- R4: Functions 5, 6 and 7 (AND, OR, XOR) and function 8 (low half of A*B) update N and Z, clear V, and keep C from `ccrIn`.
- R5: Function 10 shifts A right arithmetically, copying the sign bit into the vacated positions. Function 11 shifts A right logically, filling with zeros. The shift amount is the low log2(width) bits of B. C takes the last bit shifted out, and C is kept when the amount is zero. N and Z are updated and V is cleared.
- R6: Function 14 (link) returns `pcIn` as the result and leaves all four flags unchanged.
- R7: Function 15 places the low IMM_W bits of B in the upper IMM_W bits of the result and zeroes the rest. All flags are kept.
- R8: Functions 9, 12 and 13 return zero and leave the flags unchanged.
- R9: The condition-code word packs N in bit 0, C in bit 1, V in bit 2 and Z in bit 3. For every flag-updating function, N is the result MSB and Z is 1 exactly when the result is zero.
- R10: The data width is a parameter. The same behaviour holds at 8, 16 and 32 bits, with the sign bit at the word MSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | DATA_W | First operand |
| opB | input | DATA_W | Second operand, shift amount or immediate |
| funcCode | input | 4 | Function select |
| ccrIn | input | 4 | Present condition-code word {Z,V,C,N} |
| pcIn | input | DATA_W | Present program counter |
| result | output | DATA_W | Function result |
| ccrOut | output | 4 | Next condition-code word {Z,V,C,N} |

## Verification
Two flags can change together in one evaluation: a carry-chained subtract can produce a borrow and a signed overflow at the same time, and a result of zero can occur together with a carry out. The bench provokes these cases by sweeping every value of A against B values placed at the sign boundaries (0x7F, 0x80, 0x81, 0xFF) with Cin both clear and set. It judges all four flag bits against integer arithmetic at once. The kept-flag functions are judged with `ccrIn` patterns that differ from what the function would have computed, so a flag that is wrongly updated becomes visible at `ccrOut`.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

  typedef enum logic [3:0] {
    FN_ADD   = 4'd0,
    FN_SUB   = 4'd1,
    FN_ADC   = 4'd2,
    FN_SBC   = 4'd3,
    FN_RSUB  = 4'd4,
    FN_AND   = 4'd5,
    FN_OR    = 4'd6,
    FN_XOR   = 4'd7,
    FN_MUL   = 4'd8,
    FN_RSV9  = 4'd9,
    FN_ASR   = 4'd10,
    FN_LSR   = 4'd11,
    FN_RSV12 = 4'd12,
    FN_RSV13 = 4'd13,
    FN_LINK  = 4'd14,
    FN_UPIMM = 4'd15
  } funcE;

  typedef enum logic [1:0] { CIN_ZERO, CIN_ONE, CIN_FLAG } cinSelE;

  typedef enum logic [3:0] {
    RS_SUM, RS_AND, RS_OR, RS_XOR, RS_MUL, RS_SHIFT, RS_PC, RS_UPPER, RS_ZERO
  } resSelE;

  typedef enum logic [1:0] { CS_KEEP, CS_ADDER, CS_SHIFT } cSrcE;
  typedef enum logic [1:0] { VS_KEEP, VS_ADDER, VS_CLEAR } vSrcE;

  // Flag bit positions inside the condition-code word.
  localparam int CC_N = 0;
  localparam int CC_C = 1;
  localparam int CC_V = 2;
  localparam int CC_Z = 3;

  typedef struct packed {
    logic   swapOps;   // adder X takes B, Y takes A
    logic   invY;      // invert the adder's Y input
    cinSelE cinSel;
    logic   shArith;   // shift fills with sign bit
    resSelE resSel;
    logic   updNZ;
    cSrcE   cSrc;
    vSrcE   vSrc;
  } aluStrobesT;

endpackage

// File: rtl/flag_alu_ctrl.sv
module flag_alu_ctrl
  import flag_alu_pkg::*;
(
  input  logic [3:0] funcCode,
  output aluStrobesT strobes
);

  always_comb begin
    strobes = '{swapOps: 1'b0, invY: 1'b0, cinSel: CIN_ZERO, shArith: 1'b0,
                resSel: RS_ZERO, updNZ: 1'b0, cSrc: CS_KEEP, vSrc: VS_KEEP};
    unique case (funcE'(funcCode))
      FN_ADD: begin
        strobes.resSel = RS_SUM; strobes.updNZ = 1'b1;
        strobes.cSrc = CS_ADDER; strobes.vSrc = VS_ADDER;
      end
      FN_ADC: begin
        strobes.resSel = RS_SUM; strobes.updNZ = 1'b1; strobes.cinSel = CIN_FLAG;
        strobes.cSrc = CS_ADDER; strobes.vSrc = VS_ADDER;
      end
      FN_SUB: begin
        strobes.resSel = RS_SUM; strobes.updNZ = 1'b1; strobes.invY = 1'b1;
        strobes.cinSel = CIN_ONE; strobes.cSrc = CS_ADDER; strobes.vSrc = VS_ADDER;
      end
      FN_SBC: begin
        strobes.resSel = RS_SUM; strobes.updNZ = 1'b1; strobes.invY = 1'b1;
        strobes.cinSel = CIN_FLAG; strobes.cSrc = CS_ADDER; strobes.vSrc = VS_ADDER;
      end
      FN_RSUB: begin
        strobes.resSel = RS_SUM; strobes.updNZ = 1'b1; strobes.invY = 1'b1;
        strobes.swapOps = 1'b1; strobes.cinSel = CIN_ONE;
        strobes.cSrc = CS_ADDER; strobes.vSrc = VS_ADDER;
      end
      FN_AND: begin strobes.resSel = RS_AND; strobes.updNZ = 1'b1; strobes.vSrc = VS_CLEAR; end
      FN_OR:  begin strobes.resSel = RS_OR;  strobes.updNZ = 1'b1; strobes.vSrc = VS_CLEAR; end
      FN_XOR: begin strobes.resSel = RS_XOR; strobes.updNZ = 1'b1; strobes.vSrc = VS_CLEAR; end
      FN_MUL: begin strobes.resSel = RS_MUL; strobes.updNZ = 1'b1; strobes.vSrc = VS_CLEAR; end
      FN_ASR: begin
        strobes.resSel = RS_SHIFT; strobes.shArith = 1'b1; strobes.updNZ = 1'b1;
        strobes.cSrc = CS_SHIFT; strobes.vSrc = VS_CLEAR;
      end
      FN_LSR: begin
        strobes.resSel = RS_SHIFT; strobes.updNZ = 1'b1;
        strobes.cSrc = CS_SHIFT; strobes.vSrc = VS_CLEAR;
      end
      FN_LINK:  strobes.resSel = RS_PC;
      FN_UPIMM: strobes.resSel = RS_UPPER;
      default:  strobes.resSel = RS_ZERO;
    endcase
  end

endmodule

// File: rtl/flag_alu_datapath.sv
module flag_alu_datapath
  import flag_alu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IMM_W  = 16
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [3:0]        ccrIn,
  input  logic [DATA_W-1:0] pcIn,
  input  aluStrobesT        strobes,
  output logic [DATA_W-1:0] result,
  output logic [3:0]        ccrOut
);

  localparam int SH_W = $clog2(DATA_W);

  // Adder with operand swap and inversion
  logic [DATA_W-1:0] addX, addY, addYRaw;
  logic              addCin;
  logic [DATA_W:0]   addSum;
  logic              addCarry, addOvf;

  always_comb begin
    addX    = strobes.swapOps ? opB : opA;
    addYRaw = strobes.swapOps ? opA : opB;
    addY    = strobes.invY ? ~addYRaw : addYRaw;
    unique case (strobes.cinSel)
      CIN_ONE:  addCin = 1'b1;
      CIN_FLAG: addCin = ccrIn[CC_C];
      default:  addCin = 1'b0;
    endcase
    addSum   = {1'b0, addX} + {1'b0, addY} + {{DATA_W{1'b0}}, addCin};
    addCarry = addSum[DATA_W];
    addOvf   = (addX[DATA_W-1] == addY[DATA_W-1]) &&
               (addSum[DATA_W-1] != addX[DATA_W-1]);
  end

  // Right shifter
  logic [SH_W-1:0]   shAmt;
  logic [DATA_W-1:0] shRes, shPre;
  logic              shOut;

  always_comb begin
    shAmt = opB[SH_W-1:0];
    shRes = strobes.shArith ? DATA_W'($signed(opA) >>> shAmt) : (opA >> shAmt);
    shPre = opA >> (shAmt - SH_W'(1));
    shOut = (shAmt == '0) ? ccrIn[CC_C] : shPre[0];
  end

  // Multiplier, low half
  logic [DATA_W-1:0] mulLo;
  assign mulLo = DATA_W'(opA * opB);

  // Upper-immediate placement
  logic [DATA_W-1:0] upperImm;
  generate
    if (DATA_W > IMM_W) begin : g_upperShift
      assign upperImm = {opB[IMM_W-1:0], {(DATA_W-IMM_W){1'b0}}};
    end else begin : g_upperFull
      assign upperImm = opB;
    end
  endgenerate

  // Result select and flag merge
  always_comb begin
    unique case (strobes.resSel)
      RS_SUM:   result = addSum[DATA_W-1:0];
      RS_AND:   result = opA & opB;
      RS_OR:    result = opA | opB;
      RS_XOR:   result = opA ^ opB;
      RS_MUL:   result = mulLo;
      RS_SHIFT: result = shRes;
      RS_PC:    result = pcIn;
      RS_UPPER: result = upperImm;
      default:  result = '0;
    endcase

    ccrOut = ccrIn;
    if (strobes.updNZ) begin
      ccrOut[CC_N] = result[DATA_W-1];
      ccrOut[CC_Z] = (result == '0);
    end
    unique case (strobes.cSrc)
      CS_ADDER: ccrOut[CC_C] = addCarry;
      CS_SHIFT: ccrOut[CC_C] = shOut;
      default:  ccrOut[CC_C] = ccrIn[CC_C];
    endcase
    unique case (strobes.vSrc)
      VS_ADDER: ccrOut[CC_V] = addOvf;
      VS_CLEAR: ccrOut[CC_V] = 1'b0;
      default:  ccrOut[CC_V] = ccrIn[CC_V];
    endcase
  end

endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IMM_W  = 16
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [3:0]        funcCode,
  input  logic [3:0]        ccrIn,
  input  logic [DATA_W-1:0] pcIn,
  output logic [DATA_W-1:0] result,
  output logic [3:0]        ccrOut
);

  aluStrobesT strobes;

  flag_alu_ctrl ctrl_i (
    .funcCode (funcCode),
    .strobes  (strobes)
  );

  flag_alu_datapath #(.DATA_W(DATA_W), .IMM_W(IMM_W)) dp_i (
    .opA     (opA),
    .opB     (opB),
    .ccrIn   (ccrIn),
    .pcIn    (pcIn),
    .strobes (strobes),
    .result  (result),
    .ccrOut  (ccrOut)
  );

endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk #(
  parameter int DATA_W = 16
) (
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic [3:0]        funcCode,
  input logic [3:0]        ccrIn,
  input logic [DATA_W-1:0] pcIn,
  input logic [DATA_W-1:0] result,
  input logic [3:0]        ccrOut
);

  logic updates;
  assign updates = (funcCode <= 4'd8) || (funcCode == 4'd10) || (funcCode == 4'd11);

  always_comb begin
    if (funcCode == 4'd0) begin
      p_add_sum_r1: assert (result == DATA_W'(opA + opB));
    end
    if (funcCode == 4'd4) begin
      p_rsub_diff_r3: assert (result == DATA_W'(opB - opA));
    end
    if (funcCode >= 4'd5 && funcCode <= 4'd8) begin
      p_logic_keep_c_r4: assert (ccrOut[1] == ccrIn[1] && ccrOut[2] == 1'b0);
    end
    if (funcCode == 4'd14) begin
      p_link_pc_r6: assert (result == pcIn && ccrOut == ccrIn);
    end
    if (funcCode == 4'd9 || funcCode == 4'd12 || funcCode == 4'd13) begin
      p_reserved_quiet_r8: assert (result == '0 && ccrOut == ccrIn);
    end
    if (updates) begin
      p_nz_pack_r9: assert (ccrOut[0] == result[DATA_W-1] && ccrOut[3] == (result == '0));
    end
  end

endmodule

bind flag_alu flag_alu_chk #(.DATA_W(DATA_W)) chk_i (
  .opA      (opA),
  .opB      (opB),
  .funcCode (funcCode),
  .ccrIn    (ccrIn),
  .pcIn     (pcIn),
  .result   (result),
  .ccrOut   (ccrOut)
);

// File: tb/flag_alu_tb.sv
module flag_alu_tb_top;

  localparam int NW = 8;
  localparam int IW = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  logic [NW-1:0] a, b, pc, res;
  logic [3:0]    fn, ci, co;

  flag_alu #(.DATA_W(NW), .IMM_W(IW)) dut_i (
    .opA(a), .opB(b), .funcCode(fn), .ccrIn(ci), .pcIn(pc), .result(res), .ccrOut(co)
  );

  logic [31:0] wa, wb, wpc, wres;
  logic [3:0]  wfn, wci, wco;

  flag_alu #(.DATA_W(32), .IMM_W(16)) dutWide_i (
    .opA(wa), .opB(wb), .funcCode(wfn), .ccrIn(wci), .pcIn(wpc), .result(wres), .ccrOut(wco)
  );

  function automatic string tagOf(input logic [3:0] op);
    case (op)
      4'd0, 4'd2:   return "R1";
      4'd1, 4'd3:   return "R2";
      4'd4:         return "R3";
      4'd5, 4'd6, 4'd7, 4'd8: return "R4";
      4'd10, 4'd11: return "R5";
      4'd14:        return "R6";
      4'd15:        return "R7";
      default:      return "R8";
    endcase
  endfunction

  // Reference model for the 8-bit build, returns {ccr, result}
  function automatic logic [11:0] model(input logic [3:0] op, input logic [7:0] x,
                                        input logic [7:0] y, input logic [3:0] cc,
                                        input logic [7:0] p);
    int ux, uy, sx, sy, full, sfull, c, sh;
    logic [7:0] r;
    logic n, cf, v, z, upd;
    ux = int'(x); uy = int'(y);
    sx = int'($signed(x)); sy = int'($signed(y));
    c = int'(cc[1]);
    n = cc[0]; cf = cc[1]; v = cc[2]; z = cc[3];
    upd = 1'b1; r = 8'h00;
    case (op)
      4'd0: begin full = ux + uy; sfull = sx + sy; r = full[7:0];
                  cf = full > 255; v = (sfull > 127) || (sfull < -128); end
      4'd2: begin full = ux + uy + c; sfull = sx + sy + c; r = full[7:0];
                  cf = full > 255; v = (sfull > 127) || (sfull < -128); end
      4'd1: begin full = ux - uy; sfull = sx - sy; r = full[7:0];
                  cf = full >= 0; v = (sfull > 127) || (sfull < -128); end
      4'd3: begin full = ux - uy - (1 - c); sfull = sx - sy - (1 - c); r = full[7:0];
                  cf = full >= 0; v = (sfull > 127) || (sfull < -128); end
      4'd4: begin full = uy - ux; sfull = sy - sx; r = full[7:0];
                  cf = full >= 0; v = (sfull > 127) || (sfull < -128); end
      4'd5: begin r = x & y; v = 1'b0; end
      4'd6: begin r = x | y; v = 1'b0; end
      4'd7: begin r = x ^ y; v = 1'b0; end
      4'd8: begin full = ux * uy; r = full[7:0]; v = 1'b0; end
      4'd10, 4'd11: begin
        sh = uy % 8;
        sfull = sx;
        for (int k = 0; k < sh; k++) sfull = (sfull < 0) ? -((-sfull + 1) / 2) : sfull / 2;
        r = (op == 4'd10) ? sfull[7:0] : 8'(ux / (1 << sh));
        if (sh != 0) cf = x[sh-1];
        v = 1'b0;
      end
      4'd14: begin r = p; upd = 1'b0; end
      4'd15: begin r = {y[3:0], 4'h0}; upd = 1'b0; end
      default: begin r = 8'h00; upd = 1'b0; end
    endcase
    if (upd) begin n = r[7]; z = (r == 8'h00); end
    return {z, v, cf, n, r};
  endfunction

  task automatic checkNarrow(input logic [3:0] op, input logic [7:0] x,
                             input logic [7:0] y, input logic [3:0] cc);
    logic [11:0] exp;
    @(negedge clk);
    fn = op; a = x; b = y; ci = cc; pc = x ^ 8'h3c;
    #1;
    exp = model(op, x, y, cc, x ^ 8'h3c);
    testsRun++;
    if ({co, res} !== exp) begin
      testsFailed++;
      $display("FAIL %s (R9 R10) fn=%0d a=%h b=%h ccrIn=%b: got ccr=%b res=%h, expected ccr=%b res=%h",
               tagOf(op), op, x, y, cc, co, res, exp[11:8], exp[7:0]);
    end
  endtask

  task automatic checkWide(input string tag, input logic [3:0] op, input logic [31:0] x,
                           input logic [31:0] y, input logic [3:0] cc, input logic [31:0] p,
                           input logic [31:0] expRes, input logic [3:0] expCc);
    @(negedge clk);
    wfn = op; wa = x; wb = y; wci = cc; wpc = p;
    #1;
    testsRun++;
    if (wres !== expRes || wco !== expCc) begin
      testsFailed++;
      $display("FAIL %s fn=%0d: got res=%h ccr=%b, expected res=%h ccr=%b",
               tag, op, wres, wco, expRes, expCc);
    end
  endtask

  logic [7:0] bSet [12] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h07, 8'h55,
                            8'h7f, 8'h80, 8'h81, 8'haa, 8'hfe, 8'hff};

  initial begin
    a = '0; b = '0; fn = '0; ci = '0; pc = '0;
    wa = '0; wb = '0; wfn = '0; wci = '0; wpc = '0;
    // Quiescent check: all-zero inputs add to zero with Z set (R1, R9)
    checkNarrow(4'd0, 8'h00, 8'h00, 4'b0000);
    // Sweep: every A, boundary B values, both carry-in values, all codes
    for (int op = 0; op < 16; op++)
      for (int ai = 0; ai < 256; ai++)
        for (int bi = 0; bi < 12; bi++)
          for (int cin = 0; cin < 2; cin++)
            checkNarrow(4'(op), 8'(ai), bSet[bi],
                        {ai[3] ^ bi[0], ai[2], cin[0], ai[0] ^ bi[1]});
    // 32-bit build (R10)
    checkWide("R7 R10", 4'd15, 32'h0000abcd, 32'h0000abcd, 4'b1111, 32'h0, 32'habcd0000, 4'b1111);
    checkWide("R6 R10", 4'd14, 32'h5, 32'h6, 4'b0101, 32'h12345678, 32'h12345678, 4'b0101);
    checkWide("R1 R10", 4'd0, 32'h7fffffff, 32'h1, 4'b0000, 32'h0, 32'h80000000, 4'b0101);
    checkWide("R2 R10", 4'd1, 32'h1234, 32'h1234, 4'b0000, 32'h0, 32'h0, 4'b1010);
    checkWide("R5 R10", 4'd10, 32'h80000000, 32'd31, 4'b0010, 32'h0, 32'hffffffff, 4'b0001);
    checkWide("R5 R10", 4'd11, 32'h80000001, 32'd1, 4'b0000, 32'h0, 32'h40000000, 4'b0010);
    checkWide("R8 R10", 4'd12, 32'hffffffff, 32'h1, 4'b0110, 32'h0, 32'h0, 4'b0110);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #(4 * 190000);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule